// File: doc/BRIEF.md
# Flash page write controller

This block is the write path of an on-chip program flash. Software fills an 8-slot holding buffer one byte at a time with short table writes. Each table write places the data byte in the slot named by the low three bits of the table pointer. Software then sets up the control register and writes a two-byte key to the unlock register. Setting the start bit right after that key begins a long write. The long write merges the whole buffer into the 8-byte flash block that holds the pointer address.

During the long write a stall output holds the CPU. A cycle-count timer sets the length of the write. When the timer expires, the start bit clears itself, a one-cycle done pulse is raised and the buffer returns to all-ones. Programming can only clear bits, so the merge is a bitwise AND. A buffer slot left at FFh therefore leaves its flash byte as it was. A combinational read port shows the behavioural flash array.

Top module: `flash_page_writer`

## Requirements
- R1: A table write (`tbl_we_i`) stores `tbl_data_i` in holding slot `ptr_i[2:0]`. That slot's byte lands at offset `ptr_i[2:0]` of the programmed block and nowhere else.
- R2: Every holding slot is FFh after reset and again after each completed write. A slot not loaded since then leaves its flash byte unchanged.
- R3: Programming sets each flash byte to the old byte AND the holding byte, so no bit ever goes from 0 to 1.
- R4: A start is accepted only if the ctrl write comes right after a key write of 55h followed by a key write of AAh. Any other key value, or any table or ctrl write between these steps, breaks the key. A start request without the key is ignored and the key progress is cleared.
- R5: A start also needs the ctrl word to have write-enable (bit 1) = 1, memory-select (bit 3) = 1 and config-select (bit 2) = 0. Bit 0 is start. Otherwise no write takes place.
- R6: The programmed block is `ptr_i[7:3]` sampled in the cycle the start is accepted, whatever the pointer was during the table writes.
- R7: `stall_o` rises in the cycle after an accepted start and stays high for exactly `WRITE_CYCLES` cycles.
- R8: `ctrl_o[0]` reads 1 for the whole write and clears at completion. `done_o` pulses for one cycle in the first cycle after the stall, and by then the flash already holds the new data.
- R9: Table, ctrl and key writes made during a write are ignored.
- R10: After reset, `ctrl_o` is 0, `stall_o` and `done_o` are low and every flash byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_i | input | $clog2(FLASH_BYTES) | Table pointer |
| tbl_we_i | input | 1 | Short table write strobe |
| tbl_data_i | input | 8 | Table latch byte |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_data_i | input | 4 | Control word {mem_sel, cfg_sel, wren, start} |
| key_we_i | input | 1 | Unlock register write strobe |
| key_data_i | input | 8 | Unlock register byte |
| rd_addr_i | input | $clog2(FLASH_BYTES) | Flash read address |
| rd_data_o | output | 8 | Flash byte at rd_addr_i |
| ctrl_o | output | 4 | Control register readback |
| stall_o | output | 1 | CPU stall during long write |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench breaks the key in three ways: a wrong middle byte, a table write between the two key bytes, and a start with no key at all. A design that only checks that both key values have been seen would program flash in these cases. It also gets any single qualifier in the control word wrong, which a design that skips one of these checks would accept.

The bench loads the buffer under one pointer and starts under another. A design that latches the block during table writes would program the wrong block. It overwrites blocks that are already programmed, using partly loaded buffers. A design that assigns instead of ANDing, or that does not reset the buffer after a write, would then corrupt bytes. Writes made during a long write must leave both the buffer and the control word alone.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int unsigned SLOT_W    = 3;
  localparam int unsigned BLK_BYTES = 1 << SLOT_W;

  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_WREN  = 1;
  localparam int unsigned CTRL_CFG   = 2;
  localparam int unsigned CTRL_MEM   = 3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    ULK_IDLE  = 2'd0,
    ULK_HALF  = 2'd1,
    ULK_ARMED = 2'd2
  } ulk_state_e;
endpackage

// File: rtl/fpw_unlock.sv
module fpw_unlock
  import fpw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_i,
  input  logic       other_we_i,
  input  logic       busy_i,
  output logic       armed_o
);
  ulk_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ULK_IDLE;
    end else if (!busy_i) begin
      if (key_we_i) begin
        if (key_i == KEY_FIRST)                             state_q <= ULK_HALF;
        else if (key_i == KEY_SECOND && state_q == ULK_HALF) state_q <= ULK_ARMED;
        else                                                state_q <= ULK_IDLE;
      end else if (other_we_i) begin
        state_q <= ULK_IDLE;  // any other write consumes or breaks the key
      end
    end
  end

  assign armed_o = (state_q == ULK_ARMED);

  p_key_break_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && key_we_i && key_i != KEY_FIRST && key_i != KEY_SECOND) |=> !armed_o);

  p_armed_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(key_we_i && key_i == KEY_SECOND));
endmodule

// File: rtl/fpw_hold_buf.sv
module fpw_hold_buf
  import fpw_pkg::*;
#(
  parameter int unsigned SLOTS = BLK_BYTES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [SLOT_W-1:0]        slot_i,
  input  logic [7:0]               data_i,
  input  logic                     clear_i,
  output logic [SLOTS*8-1:0]       hold_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  byte_q <= 8'hFF;
      else if (clear_i)                             byte_q <= 8'hFF;
      else if (we_i && slot_i == SLOT_W'(g))        byte_q <= data_i;
    end
    assign hold_o[g*8 +: 8] = byte_q;
  end

  p_clear_ff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hold_o == '1));
endmodule

// File: rtl/fpw_timer.sv
module fpw_timer #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic finish_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign finish_o = busy_q && (cnt_q == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_o;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (finish_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CNT_W'(CYCLES)));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/fpw_array.sv
module fpw_array
  import fpw_pkg::*;
#(
  parameter int unsigned BYTES = 256
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         prog_i,
  input  logic [$clog2(BYTES)-SLOT_W-1:0] blk_i,
  input  logic [BLK_BYTES*8-1:0]       hold_i,
  input  logic [$clog2(BYTES)-1:0]     rd_addr_i,
  output logic [7:0]                   rd_data_o
);
  localparam int unsigned ADDR_W = $clog2(BYTES);

  logic [7:0] mem_q [BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < BYTES; a++) mem_q[a] <= 8'hFF;
    end else if (prog_i) begin
      for (int s = 0; s < BLK_BYTES; s++) begin
        mem_q[{blk_i, SLOT_W'(s)}] <= mem_q[{blk_i, SLOT_W'(s)}] & hold_i[s*8 +: 8];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  logic [ADDR_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import fpw_pkg::*;
#(
  parameter int unsigned FLASH_BYTES  = 256,
  parameter int unsigned WRITE_CYCLES = 250000
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [$clog2(FLASH_BYTES)-1:0] ptr_i,
  input  logic                           tbl_we_i,
  input  logic [7:0]                     tbl_data_i,
  input  logic                           ctrl_we_i,
  input  logic [3:0]                     ctrl_data_i,
  input  logic                           key_we_i,
  input  logic [7:0]                     key_data_i,
  input  logic [$clog2(FLASH_BYTES)-1:0] rd_addr_i,
  output logic [7:0]                     rd_data_o,
  output logic [3:0]                     ctrl_o,
  output logic                           stall_o,
  output logic                           done_o
);
  localparam int unsigned ADDR_W = $clog2(FLASH_BYTES);
  localparam int unsigned BLK_W  = ADDR_W - SLOT_W;

  logic busy, finish, armed, go;
  logic mem_q, cfg_q, wren_q, start_q;
  logic [BLK_W-1:0] blk_q;
  logic [BLK_BYTES*8-1:0] hold;

  assign go = ctrl_we_i && !busy && armed
           && ctrl_data_i[CTRL_START] && ctrl_data_i[CTRL_WREN]
           && ctrl_data_i[CTRL_MEM]   && !ctrl_data_i[CTRL_CFG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= 1'b0;
      cfg_q   <= 1'b0;
      wren_q  <= 1'b0;
      start_q <= 1'b0;
      blk_q   <= '0;
    end else if (ctrl_we_i && !busy) begin
      mem_q   <= ctrl_data_i[CTRL_MEM];
      cfg_q   <= ctrl_data_i[CTRL_CFG];
      wren_q  <= ctrl_data_i[CTRL_WREN];
      start_q <= go;
      if (go) blk_q <= ptr_i[ADDR_W-1:SLOT_W];
    end else if (finish) begin
      start_q <= 1'b0;
    end
  end

  fpw_unlock u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_we_i   (key_we_i),
    .key_i      (key_data_i),
    .other_we_i (tbl_we_i || ctrl_we_i),
    .busy_i     (busy),
    .armed_o    (armed)
  );

  fpw_hold_buf #(.SLOTS(BLK_BYTES)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i && !busy),
    .slot_i  (ptr_i[SLOT_W-1:0]),
    .data_i  (tbl_data_i),
    .clear_i (finish),
    .hold_o  (hold)
  );

  fpw_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go),
    .busy_o   (busy),
    .finish_o (finish),
    .done_o   (done_o)
  );

  fpw_array #(.BYTES(FLASH_BYTES)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_i    (finish),
    .blk_i     (blk_q),
    .hold_i    (hold),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign ctrl_o  = {mem_q, cfg_q, wren_q, start_q};
  assign stall_o = busy;

  p_start_keyed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(armed));

  p_start_qual_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> (wren_q && mem_q && !cfg_q));

  p_start_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q == busy);
endmodule

// File: tb/flash_page_writer_test.sv
`timescale 1ns/1ps
module flash_page_writer_test;
  localparam int N     = 20;
  localparam int BYTES = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ptr = '0, tbl_d = '0, key_d = '0, rd_addr = '0;
  logic       tbl_we = 1'b0, ctrl_we = 1'b0, key_we = 1'b0;
  logic [3:0] ctrl_d = '0;
  logic [7:0] rd_data;
  logic [3:0] ctrl_q;
  logic       stall, done;

  int checks = 0, errors = 0;
  int exp_q[$];
  int stall_cnt = 0;
  logic [7:0] model_mem [BYTES];
  logic [7:0] model_hold [8];

  always #4 clk = ~clk;

  flash_page_writer #(.FLASH_BYTES(BYTES), .WRITE_CYCLES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ptr_i(ptr), .tbl_we_i(tbl_we), .tbl_data_i(tbl_d),
    .ctrl_we_i(ctrl_we), .ctrl_data_i(ctrl_d), .key_we_i(key_we), .key_data_i(key_d),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ctrl_o(ctrl_q), .stall_o(stall), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected stall length on each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall) stall_cnt++;
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected write completion", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(stall_cnt == e, "R7", "stall length", stall_cnt, e);
        end
        stall_cnt = 0;
      end
    end
  end

  task automatic tbl_wr(input logic [7:0] p, input logic [7:0] d, input bit track);
    @(negedge clk); ptr = p; tbl_d = d; tbl_we = 1'b1;
    @(posedge clk); #1 tbl_we = 1'b0;
    if (track) model_hold[p[2:0]] = d;
  endtask

  task automatic ctrl_wr(input logic [3:0] d);
    @(negedge clk); ctrl_d = d; ctrl_we = 1'b1;
    @(posedge clk); #1 ctrl_we = 1'b0;
  endtask

  task automatic key_wr(input logic [7:0] d);
    @(negedge clk); key_d = d; key_we = 1'b1;
    @(posedge clk); #1 key_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_byte(input logic [7:0] a, input string req);
    rd_addr = a; #1;
    check(rd_data == model_mem[a], req, $sformatf("flash[%0h]", a), rd_data, model_mem[a]);
  endtask

  task automatic check_block(input logic [7:0] base, input string req);
    for (int s = 0; s < 8; s++) check_byte(base + 8'(s), req);
  endtask

  // accepted start: expects a write into block of p
  task automatic good_write(input logic [7:0] p);
    bit seen = 1'b0;
    ctrl_wr(4'b1010); key_wr(8'h55); key_wr(8'hAA);
    @(negedge clk); ptr = p;
    exp_q.push_back(N);
    ctrl_wr(4'b1011);
    @(negedge clk);
    check(ctrl_q[0] == 1'b1, "R8", "start bit during write", ctrl_q[0], 1);
    check(stall == 1'b1, "R7", "stall after start", stall, 1);
    for (int i = 0; i < N + 10 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen, "R8", "done pulse seen", seen, 1);
    check(ctrl_q[0] == 1'b0, "R8", "start bit cleared", ctrl_q[0], 0);
    for (int s = 0; s < 8; s++) begin
      model_mem[{p[7:3], 3'(s)}] = model_mem[{p[7:3], 3'(s)}] & model_hold[s];
      model_hold[s] = 8'hFF;
    end
  endtask

  task automatic expect_ignored(input string req);
    idle(N + 4);
    check(stall == 1'b0, req, "no stall", stall, 0);
    check(ctrl_q[0] == 1'b0, req, "start bit stays clear", ctrl_q[0], 0);
  endtask

  initial begin
    for (int a = 0; a < BYTES; a++) model_mem[a] = 8'hFF;
    for (int s = 0; s < 8; s++) model_hold[s] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(ctrl_q == 4'h0, "R10", "ctrl after reset", ctrl_q, 0);
    check(stall == 1'b0 && done == 1'b0, "R10", "stall/done after reset", {stall, done}, 0);
    check_byte(8'h00, "R10");
    check_byte(8'hFF, "R10");

    // R1 full block, slots loaded in scrambled order
    for (int i = 7; i >= 0; i--) tbl_wr(8'h20 + 8'(i), 8'(8'h3C ^ (i * 8'h11)), 1'b1);
    good_write(8'h20);
    check_block(8'h20, "R1");
    check_byte(8'h1F, "R1");
    check_byte(8'h28, "R1");

    // R3 AND merge, R2 unloaded slots untouched
    tbl_wr(8'h21, 8'h0F, 1'b1);
    tbl_wr(8'h24, 8'hF0, 1'b1);
    good_write(8'h22);
    check_block(8'h20, "R3");
    good_write(8'h27);  // nothing loaded: buffer back to FFh
    check_block(8'h20, "R2");

    // R4 broken key sequences
    tbl_wr(8'h40, 8'h12, 1'b1);
    ctrl_wr(4'b1010); key_wr(8'h55); key_wr(8'h00); key_wr(8'hAA);
    @(negedge clk); ptr = 8'h40; ctrl_wr(4'b1011);
    expect_ignored("R4");
    check_byte(8'h40, "R4");
    ctrl_wr(4'b1010); key_wr(8'h55); tbl_wr(8'h43, 8'h34, 1'b1); key_wr(8'hAA);
    @(negedge clk); ptr = 8'h40; ctrl_wr(4'b1011);
    expect_ignored("R4");
    ctrl_wr(4'b1011);  // no key at all
    expect_ignored("R4");
    check_byte(8'h43, "R4");
    good_write(8'h40);  // held data survived the refusals
    check_block(8'h40, "R4");

    // R5 qualifier bits
    tbl_wr(8'h50, 8'h00, 1'b1);
    ctrl_wr(4'b1010); key_wr(8'h55); key_wr(8'hAA); @(negedge clk); ptr = 8'h50; ctrl_wr(4'b1001);
    expect_ignored("R5");
    ctrl_wr(4'b1010); key_wr(8'h55); key_wr(8'hAA); @(negedge clk); ptr = 8'h50; ctrl_wr(4'b1111);
    expect_ignored("R5");
    ctrl_wr(4'b1010); key_wr(8'h55); key_wr(8'hAA); @(negedge clk); ptr = 8'h50; ctrl_wr(4'b0011);
    expect_ignored("R5");
    check_byte(8'h50, "R5");
    good_write(8'h50);
    check_byte(8'h50, "R5");

    // R6 block chosen by pointer at start
    for (int i = 0; i < 4; i++) tbl_wr(8'h60 + 8'(i), 8'(8'hA0 + i), 1'b1);
    good_write(8'h8D);
    check_block(8'h88, "R6");
    check_byte(8'h60, "R6");

    // R9 writes during a long write are ignored
    tbl_wr(8'hA0, 8'h55, 1'b1);
    ctrl_wr(4'b1010); key_wr(8'h55); key_wr(8'hAA);
    @(negedge clk); ptr = 8'hA0;
    exp_q.push_back(N);
    ctrl_wr(4'b1011);
    tbl_wr(8'hC0, 8'h00, 1'b0);
    ctrl_wr(4'b0000);
    key_wr(8'h55);
    @(negedge clk);
    check(ctrl_q == 4'b1011, "R9", "ctrl during write", ctrl_q, 4'hB);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < N + 10 && !seen; i++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      check(seen, "R8", "done pulse seen", seen, 1);
    end
    model_mem[8'hA0] = model_mem[8'hA0] & 8'h55;
    for (int s = 0; s < 8; s++) model_hold[s] = 8'hFF;
    check_byte(8'hA0, "R9");
    good_write(8'hC0);
    check_byte(8'hC0, "R9");

    idle(4);
    check(exp_q.size() == 0, "R7", "pending expected writes", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule